// File: doc/BRIEF.md
# Rational Resize Phase Sequencer

This block turns one reduced resize ratio into the list of per-phase entries that a resampling filter walks through. The ratio is given as an output count over an input count. Each entry holds a blend weight for the nearer source sample and the number of source samples to step past after that phase. A start pulse loads the ratio. The block then emits one entry per output phase as a valid-qualified stream, and a single done pulse closes the sequence. A coefficient generator or a filter lookup table consumes the stream downstream.

The ratio class picks one of three stepping rules. When the input count is larger, the ratio is a reduction. When the input count is one, the ratio is an integer enlargement. Any other enlargement is fractional. A 1:1 ratio switches resizing off for the axis. Ratios the table cannot hold are refused. Weights are on a scale where 512 means all of the nearer sample. Divisions and remainders are computed by one small iterative divider, so valid stays low while each entry is being worked out.

Top module: `rsz_phase_seq`

## Requirements
- R1: A ratio whose output count exceeds MAX_PHASES (31), or whose output or input count is zero, is refused. `ratio_err` and `done` pulse together, no entry is emitted, and `resize_en` reads 0 with `lut_index` 0 from the cycle after start.
- R2: A 1:1 ratio emits no entry and pulses `done` without `ratio_err`. From the cycle after start, `resize_en` reads 0 and `lut_index` reads 0.
- R3: For any other accepted ratio n:d, `resize_en` reads 1 and `lut_index` reads n−1 from the cycle after start.
- R4: An accepted resizing ratio produces exactly n entries. `done` is high for one cycle, in the cycle right after the last entry. `busy` is low while `done` is high.
- R5: Fractional enlargement (1 < d < n) starts with a zero accumulator a. Each phase emits weight 512 − ⌊512·a/n⌋, then adds d to a. If a ≥ n, the phase emits advance 1 and n is subtracted from a. Otherwise it emits advance 0.
- R6: Integer enlargement (d = 1, n > 1) emits weight 512 with `ent_nearest` = 1 on every phase. Advance is 1 on the last phase only.
- R7: Reduction (d > n) keeps a remainder r, which starts at (d − n) mod 2n. Each phase emits weight 512 − ⌊512·r/(2n)⌋. It then forms x = r + 2d, emits advance ⌊x/(2n)⌋, and sets r = x mod 2n. Every reduction entry carries `ent_down` = 1 and `ent_nearest` = 0.
- R8: Enlargement entries carry `ent_down` = 0. Fractional enlargement entries also carry `ent_nearest` = 0.
- R9: A start pulse while `busy` is high is ignored. The running sequence, `lut_index` and `resize_en` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads the ratio and begins a sequence when idle |
| ratio_num | input | RATIO_W | Output count n of the reduced ratio |
| ratio_den | input | RATIO_W | Input count d of the reduced ratio |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse closing a sequence |
| ratio_err | output | 1 | Pulses with done when the ratio was refused |
| resize_en | output | 1 | Resizing active on this axis for the loaded ratio |
| lut_index | output | IDX_W | Highest table index in use (n−1) |
| ent_valid | output | 1 | Entry fields are valid this cycle |
| ent_weight | output | WT_LOG2+1 | Weight of the nearer sample, 512 = full |
| ent_adv | output | RATIO_W | Source samples to step after this phase |
| ent_down | output | 1 | Entry belongs to a reduction |
| ent_nearest | output | 1 | Entry requests nearest-sample filtering |

## Verification
`lut_index` and `resize_en` are due one cycle after the start edge. The bench samples them at the falling edge right after start drops. Entries come after data-dependent divider waits, so there is no fixed cycle in which to look for them. Instead, a monitor compares each entry, on any falling edge where valid is high, against the head of a queue that a software model filled. `done` has to land exactly one cycle after the last entry. The bench checks this by comparing cycle stamps taken when the last entry and `done` were seen. For refused and 1:1 ratios, `done` must appear with no entry seen at all.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
   typedef enum logic [1:0] {
      RM_UNITY   = 2'd0,
      RM_INT_UP  = 2'd1,
      RM_FRAC_UP = 2'd2,
      RM_DOWN    = 2'd3
   } rsz_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_PREP = 3'd1,
      SQ_STEP = 3'd2,
      SQ_WT   = 3'd3,
      SQ_ADV  = 3'd4,
      SQ_FIN  = 3'd5
   } rsz_state_e;
endpackage

// File: rtl/rsz_ratio_class.sv
module rsz_ratio_class
   import rsz_pkg::*;
#(
   parameter int RATIO_W    = 6,
   parameter int MAX_PHASES = 31
) (
   input  logic [RATIO_W-1:0] num_i,
   input  logic [RATIO_W-1:0] den_i,
   output rsz_mode_e          mode_o,
   output logic               bad_o
);
   localparam logic [RATIO_W-1:0] LIMIT = RATIO_W'(MAX_PHASES);
   localparam logic [RATIO_W-1:0] ONE   = RATIO_W'(1);

   always_comb begin
      bad_o = (num_i == '0) || (den_i == '0) || (num_i > LIMIT);
      if (num_i == den_i)      mode_o = RM_UNITY;
      else if (den_i > num_i)  mode_o = RM_DOWN;
      else if (den_i == ONE)   mode_o = RM_INT_UP;
      else                     mode_o = RM_FRAC_UP;
   end
endmodule

// File: rtl/rsz_seq_divider.sv
module rsz_seq_divider #(
   parameter int DD_W = 16,
   parameter int DS_W = 7,
   parameter int QW   = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic [DD_W-1:0] dividend_i,
   input  logic [DS_W-1:0] divisor_i,
   output logic [QW-1:0]   quo_o,
   output logic [DS_W-1:0] rem_o,
   output logic            fin_o
);
   localparam int CNT_W = $clog2(DD_W + 1);

   logic [DD_W-1:0]  q_sh;
   logic [DS_W-1:0]  r_acc;
   logic [DS_W-1:0]  dv;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [DS_W:0]    r_try;
   logic             fits;

   generate
      if (QW > DD_W) begin : g_bad_qw
         $error("quotient width larger than dividend width");
      end
      if (DD_W < 2) begin : g_bad_dd
         $error("dividend width must be at least 2");
      end
   endgenerate

   assign r_try = {r_acc, q_sh[DD_W-1]};
   assign fits  = r_try >= {1'b0, dv};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sh  <= '0;
         r_acc <= '0;
         dv    <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            q_sh  <= dividend_i;
            r_acc <= '0;
            dv    <= divisor_i;
            cnt   <= CNT_W'(DD_W);
            run   <= 1'b1;
         end else if (run) begin
            r_acc <= fits ? DS_W'(r_try - {1'b0, dv}) : r_try[DS_W-1:0];
            q_sh  <= {q_sh[DD_W-2:0], fits};
            cnt   <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               run   <= 1'b0;
               fin_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = QW'(q_sh);
   assign rem_o = r_acc;
endmodule

// File: rtl/rsz_phase_seq.sv
module rsz_phase_seq
   import rsz_pkg::*;
#(
   parameter int RATIO_W    = 6,
   parameter int MAX_PHASES = 31,
   parameter int WT_LOG2    = 9,
   localparam int IDX_W     = (MAX_PHASES > 1) ? $clog2(MAX_PHASES) : 1,
   localparam int WT_W      = WT_LOG2 + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [RATIO_W-1:0] ratio_num,
   input  logic [RATIO_W-1:0] ratio_den,
   output logic               busy,
   output logic               done,
   output logic               ratio_err,
   output logic               resize_en,
   output logic [IDX_W-1:0]   lut_index,
   output logic               ent_valid,
   output logic [WT_W-1:0]    ent_weight,
   output logic [RATIO_W-1:0] ent_adv,
   output logic               ent_down,
   output logic               ent_nearest
);
   localparam int DS_W = RATIO_W + 1;
   localparam int DD_W = WT_LOG2 + RATIO_W + 1;
   localparam int QW   = (WT_W > RATIO_W) ? WT_W : RATIO_W;
   localparam logic [WT_W-1:0] WT_FULL = {1'b1, {WT_LOG2{1'b0}}};

   generate
      if (MAX_PHASES < 1 || MAX_PHASES >= (1 << RATIO_W)) begin : g_bad_phases
         $error("MAX_PHASES must lie in 1 .. 2**RATIO_W-1");
      end
      if (WT_LOG2 < 1) begin : g_bad_wt
         $error("WT_LOG2 must be at least 1");
      end
   endgenerate

   rsz_state_e         st;
   rsz_mode_e          mode_q;
   rsz_mode_e          cls_mode;
   logic               cls_bad;
   logic [RATIO_W-1:0] num_q, den_q;
   logic [IDX_W-1:0]   phase;
   logic [DS_W-1:0]    acc;
   logic [WT_W-1:0]    wt_hold;
   logic               err_q;

   logic               div_go;
   logic [DD_W-1:0]    div_a;
   logic [DS_W-1:0]    div_b;
   logic [QW-1:0]      div_quo;
   logic [DS_W-1:0]    div_rem;
   logic               div_fin;

   rsz_ratio_class #(.RATIO_W(RATIO_W), .MAX_PHASES(MAX_PHASES)) u_class (
      .num_i  (ratio_num),
      .den_i  (ratio_den),
      .mode_o (cls_mode),
      .bad_o  (cls_bad)
   );

   rsz_seq_divider #(.DD_W(DD_W), .DS_W(DS_W), .QW(QW)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (div_go),
      .dividend_i (div_a),
      .divisor_i  (div_b),
      .quo_o      (div_quo),
      .rem_o      (div_rem),
      .fin_o      (div_fin)
   );

   logic [DS_W-1:0] num_x, twice_num;
   logic            last_ph;
   logic [DS_W:0]   up_sum;
   logic            up_wrap;
   logic [WT_W-1:0] wt_calc;

   assign num_x     = {1'b0, num_q};
   assign twice_num = {num_q, 1'b0};
   assign last_ph   = (DS_W'(phase) == (num_x - DS_W'(1)));
   assign up_sum    = {1'b0, acc} + (DS_W+1)'(den_q);
   assign up_wrap   = up_sum >= (DS_W+1)'(num_q);
   assign wt_calc   = WT_FULL - WT_W'(div_quo);
   assign busy      = (st != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         mode_q      <= RM_UNITY;
         num_q       <= '0;
         den_q       <= '0;
         phase       <= '0;
         acc         <= '0;
         wt_hold     <= '0;
         err_q       <= 1'b0;
         div_go      <= 1'b0;
         div_a       <= '0;
         div_b       <= '0;
         done        <= 1'b0;
         ratio_err   <= 1'b0;
         resize_en   <= 1'b0;
         lut_index   <= '0;
         ent_valid   <= 1'b0;
         ent_weight  <= '0;
         ent_adv     <= '0;
         ent_down    <= 1'b0;
         ent_nearest <= 1'b0;
      end else begin
         div_go    <= 1'b0;
         done      <= 1'b0;
         ratio_err <= 1'b0;
         ent_valid <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  num_q  <= ratio_num;
                  den_q  <= ratio_den;
                  mode_q <= cls_mode;
                  phase  <= '0;
                  acc    <= '0;
                  if (cls_bad || cls_mode == RM_UNITY) begin
                     err_q     <= cls_bad;
                     resize_en <= 1'b0;
                     lut_index <= '0;
                     st        <= SQ_FIN;
                  end else begin
                     err_q     <= 1'b0;
                     resize_en <= 1'b1;
                     lut_index <= IDX_W'(ratio_num - 1'b1);
                     if (cls_mode == RM_DOWN) begin
                        div_go <= 1'b1;
                        div_a  <= DD_W'(ratio_den - ratio_num);
                        div_b  <= {ratio_num, 1'b0};
                        st     <= SQ_PREP;
                     end else begin
                        st <= SQ_STEP;
                     end
                  end
               end
            end
            SQ_PREP: begin
               if (div_fin) begin
                  acc <= div_rem;
                  st  <= SQ_STEP;
               end
            end
            SQ_STEP: begin
               if (mode_q == RM_INT_UP) begin
                  ent_valid   <= 1'b1;
                  ent_weight  <= WT_FULL;
                  ent_adv     <= last_ph ? RATIO_W'(1) : '0;
                  ent_down    <= 1'b0;
                  ent_nearest <= 1'b1;
                  phase       <= phase + 1'b1;
                  st          <= last_ph ? SQ_FIN : SQ_STEP;
               end else begin
                  div_go <= 1'b1;
                  div_a  <= DD_W'({acc, {WT_LOG2{1'b0}}});
                  div_b  <= (mode_q == RM_DOWN) ? twice_num : num_x;
                  st     <= SQ_WT;
               end
            end
            SQ_WT: begin
               if (div_fin) begin
                  if (mode_q == RM_DOWN) begin
                     wt_hold <= wt_calc;
                     div_go  <= 1'b1;
                     div_a   <= DD_W'(acc) + DD_W'({den_q, 1'b0});
                     div_b   <= twice_num;
                     st      <= SQ_ADV;
                  end else begin
                     acc         <= up_wrap ? DS_W'(up_sum - (DS_W+1)'(num_q))
                                            : DS_W'(up_sum);
                     ent_valid   <= 1'b1;
                     ent_weight  <= wt_calc;
                     ent_adv     <= up_wrap ? RATIO_W'(1) : '0;
                     ent_down    <= 1'b0;
                     ent_nearest <= 1'b0;
                     phase       <= phase + 1'b1;
                     st          <= last_ph ? SQ_FIN : SQ_STEP;
                  end
               end
            end
            SQ_ADV: begin
               if (div_fin) begin
                  acc         <= div_rem;
                  ent_valid   <= 1'b1;
                  ent_weight  <= wt_hold;
                  ent_adv     <= RATIO_W'(div_quo);
                  ent_down    <= 1'b1;
                  ent_nearest <= 1'b0;
                  phase       <= phase + 1'b1;
                  st          <= last_ph ? SQ_FIN : SQ_STEP;
               end
            end
            SQ_FIN: begin
               done      <= 1'b1;
               ratio_err <= err_q;
               st        <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rsz_phase_seq_chk.sv
module rsz_phase_seq_chk #(
   parameter int RATIO_W    = 6,
   parameter int MAX_PHASES = 31,
   parameter int WT_LOG2    = 9,
   localparam int IDX_W     = (MAX_PHASES > 1) ? $clog2(MAX_PHASES) : 1,
   localparam int WT_W      = WT_LOG2 + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               ratio_err,
   input logic               resize_en,
   input logic [IDX_W-1:0]   lut_index,
   input logic               ent_valid,
   input logic [WT_W-1:0]    ent_weight,
   input logic               ent_down,
   input logic               ent_nearest
);
   localparam logic [WT_W-1:0] WT_FULL = {1'b1, {WT_LOG2{1'b0}}};

   logic [IDX_W:0] ent_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ent_cnt <= '0;
      else if (start && !busy)    ent_cnt <= '0;
      else if (ent_valid)         ent_cnt <= ent_cnt + 1'b1;
   end

   // R1: a refusal is reported only together with done and resizing off
   a_r1_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_err |-> (done && !resize_en));

   // R1 and R2: no entry when resizing is off
   a_r2_no_entries: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !resize_en) |-> (ent_cnt == '0));

   // R3: an accepted start always makes the block busy
   a_r3_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R4: sequence length equals table index plus one
   a_r4_length: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resize_en) |-> (ent_cnt == ((IDX_W+1)'(lut_index) + 1'b1)));

   // R4: entries and done stay apart, entries only while busy
   a_r4_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> (busy && !done));

   // R5: weights stay in 1 .. full scale
   a_r5_weight_range: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> ((ent_weight != '0) && (ent_weight <= WT_FULL)));

   // R6: nearest entries carry full weight and are never reductions
   a_r6_nearest_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid && ent_nearest) |-> ((ent_weight == WT_FULL) && !ent_down));

   // R9: start during a sequence leaves the loaded configuration alone
   a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(lut_index) && $stable(resize_en)));
endmodule

bind rsz_phase_seq rsz_phase_seq_chk #(
   .RATIO_W    (RATIO_W),
   .MAX_PHASES (MAX_PHASES),
   .WT_LOG2    (WT_LOG2)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .ratio_err   (ratio_err),
   .resize_en   (resize_en),
   .lut_index   (lut_index),
   .ent_valid   (ent_valid),
   .ent_weight  (ent_weight),
   .ent_down    (ent_down),
   .ent_nearest (ent_nearest)
);

// File: tb/rsz_phase_seq_tb_top.sv
module rsz_phase_seq_tb_top;
   localparam int RATIO_W = 6;
   localparam int MAXP    = 31;
   localparam int IDX_W   = 5;
   localparam int WT_W    = 10;
   localparam int IW      = 2 + RATIO_W + WT_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [RATIO_W-1:0] ratio_num = '0;
   logic [RATIO_W-1:0] ratio_den = '0;
   logic               busy, done, ratio_err, resize_en;
   logic [IDX_W-1:0]   lut_index;
   logic               ent_valid;
   logic [WT_W-1:0]    ent_weight;
   logic [RATIO_W-1:0] ent_adv;
   logic               ent_down, ent_nearest;

   always #4 clk = ~clk;

   rsz_phase_seq #(.RATIO_W(RATIO_W), .MAX_PHASES(MAXP), .WT_LOG2(9)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ratio_num(ratio_num), .ratio_den(ratio_den),
      .busy(busy), .done(done), .ratio_err(ratio_err),
      .resize_en(resize_en), .lut_index(lut_index),
      .ent_valid(ent_valid), .ent_weight(ent_weight), .ent_adv(ent_adv),
      .ent_down(ent_down), .ent_nearest(ent_nearest)
   );

   int nvec = 0;
   int nmis = 0;
   int cyc = 0;
   int got_n = 0;
   int last_cyc = 0;
   string cur_tag = "R5";
   logic [IW-1:0] exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nmis++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int gcd_f(input int a, input int b);
      int x = a;
      int y = b;
      while (y != 0) begin
         int t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic logic [IW-1:0] mk(input bit dn, input bit nr, input int adv, input int w);
      return {dn, nr, RATIO_W'(adv), WT_W'(w)};
   endfunction

   // software model straight from R5, R6, R7
   task automatic build_model(input int n, input int d);
      int acc;
      exp_q.delete();
      if (d > n) begin
         cur_tag = "R7";
         acc = d;
         for (int i = 0; i < n; i++) begin
            int w, off;
            acc = n + (acc - n) % (2 * n);
            w   = 512 - 512 * (acc - n) / (2 * n);
            acc = acc + 2 * d;
            off = (acc - n) / (2 * n);
            exp_q.push_back(mk(1'b1, 1'b0, off, w));
         end
      end else if (d == 1) begin
         cur_tag = "R6";
         for (int i = 0; i < n; i++)
            exp_q.push_back(mk(1'b0, 1'b1, (i == n - 1) ? 1 : 0, 512));
      end else begin
         cur_tag = "R5 R8";
         acc = 0;
         for (int i = 0; i < n; i++) begin
            int w, off;
            w   = 512 - 512 * acc / n;
            acc = acc + d;
            off = (acc >= n) ? 1 : 0;
            if (off == 1) acc = acc - n;
            exp_q.push_back(mk(1'b0, 1'b0, off, w));
         end
      end
   endtask

   // monitor: pops the scoreboard as entries appear
   always @(negedge clk) begin
      if (rst_n && ent_valid) begin
         logic [IW-1:0] act;
         act = {ent_down, ent_nearest, ent_adv, ent_weight};
         got_n++;
         last_cyc = cyc;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 extra entry", act, 0);
         end else begin
            logic [IW-1:0] e;
            e = exp_q.pop_front();
            chk(act == e, cur_tag, act, e);
         end
      end
   end

   task automatic run_ratio(input int n, input int d, input bit poke);
      bit bad, unity;
      int exp_n;
      bad   = (n == 0) || (d == 0) || (n > MAXP);
      unity = !bad && (n == d);
      exp_n = (bad || unity) ? 0 : n;
      if (bad || unity) exp_q.delete();
      else build_model(n, d);
      got_n = 0;
      @(negedge clk);
      ratio_num = RATIO_W'(n);
      ratio_den = RATIO_W'(d);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (bad) begin
         chk(resize_en == 1'b0 && lut_index == '0, "R1 config", {resize_en, lut_index}, 0);
      end else if (unity) begin
         chk(resize_en == 1'b0 && lut_index == '0, "R2 config", {resize_en, lut_index}, 0);
      end else begin
         chk(resize_en == 1'b1, "R3 resize_en", resize_en, 1);
         chk(lut_index == IDX_W'(n - 1), "R3 lut_index", lut_index, n - 1);
      end
      if (poke) begin
         @(negedge clk);
         ratio_num = 6'd3;
         ratio_den = 6'd2;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         chk(lut_index == IDX_W'(n - 1) && resize_en, "R9 config kept", lut_index, n - 1);
      end
      while (done !== 1'b1) @(negedge clk);
      chk(ratio_err == bad, bad ? "R1 err" : "R2 err", ratio_err, bad);
      chk(got_n == exp_n, "R4 count", got_n, exp_n);
      chk(busy == 1'b0, "R4 idle at done", busy, 0);
      if (exp_n > 0)
         chk(cyc == last_cyc + 1, "R4 done timing", cyc - last_cyc, 1);
      if (poke)
         chk(exp_q.size() == 0, "R9 sequence intact", exp_q.size(), 0);
      @(negedge clk);
      chk(done == 1'b0, "R4 done one cycle", done, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nmis++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

   initial begin
      int dl[6] = '{1, 2, 3, 7, 19, 31};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !ent_valid && !ratio_err, "R4 reset outputs",
          {busy, done, ent_valid, ratio_err}, 0);
      chk(!resize_en && lut_index == '0, "R3 reset config", {resize_en, lut_index}, 0);

      run_ratio(32, 5, 1'b0);
      run_ratio(0, 3, 1'b0);
      run_ratio(4, 0, 1'b0);
      run_ratio(63, 1, 1'b0);
      run_ratio(1, 1, 1'b0);
      run_ratio(5, 31, 1'b1);

      for (int n = 1; n <= MAXP; n++) begin
         foreach (dl[k]) begin
            if (gcd_f(n, dl[k]) == 1 && !(n == 1 && dl[k] == 1))
               run_ratio(n, dl[k], 1'b0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end
endmodule